// File: doc/BRIEF.md
# UART Queue Flush, Flow-Control and Receive Idle Timeout

This block sits between a UART's register interface and its serial shifters and owns the two character queues: one for outgoing characters (filled by software, drained by the transmitter) and one for incoming characters (filled by the receiver, drained by software). It empties either queue on request. It empties both queues and drops the UART clock enable whenever the UART is switched off.

A flush is requested by a control write whose flush bit is 1. The flush bit then reads back as busy until the queue has been cleared, and afterwards it clears itself. A control write with the flush bit at 0 changes nothing. The receive queue fill level drives a request-to-send output with hysteresis, so a remote sender is held off before the queue overruns. The active level of that output is programmable.

The block also raises an interrupt when characters have sat unread in the receive queue for a programmed number of character times. Character times arrive as a one-cycle strobe from the baud logic. The interrupt count restarts on every read, and a programmed count of zero turns the interrupt off.

Top module: `uartQueueCtl`

## Requirements
- R1: Each queue returns characters in the order they were pushed, with the oldest character shown on its read-data output before it is popped. `txFull`/`rxFull` are high when DEPTH characters are held, and a push while full is dropped.
- R2: A control write with `ctlTxFlush`=1 makes `txFlushBusy` read 1 for exactly the two cycles after the write. The transmit queue is empty from the second cycle on, and pushes during the busy window are dropped.
- R3: A control write with `ctlRxFlush`=1 behaves the same way for the receive queue (`rxFlushBusy`). It also clears a pending timeout interrupt.
- R4: A control write with both flush bits at 0 leaves both queues' contents untouched and sets no busy flag.
- R5: While `enable` is 0, both queues are held empty, pushes are dropped, `clkEnOut` is 0 and the timeout interrupt is 0.
- R6: When the receive queue is non-empty and unread, `toIrq` goes to 1 on the clock edge of the `toCount`-th `charTick` and not earlier.
- R7: Any accepted receive pop, and any empty receive queue, restarts the character-time count from zero.
- R8: With `toCount`=0 the timeout interrupt never rises.
- R9: Once raised, `toIrq` stays 1 until the receive queue is read or flushed, whatever further ticks arrive.
- R10: With flow control on, request-to-send is deasserted one cycle after the receive queue has fewer than 2 free entries. It stays deasserted until at least 4 entries are free, and is then reasserted one cycle later.
- R11: The asserted level of `rtsOut` is 0 when `flowPol`=0 and 1 when `flowPol`=1. With `flowEn`=0, `rtsOut` is held at the asserted level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | UART on; 0 flushes both queues and gates the clock |
| ctlWrite | input | 1 | One-cycle strobe: control register write |
| ctlTxFlush | input | 1 | Transmit-flush bit of the write data |
| ctlRxFlush | input | 1 | Receive-flush bit of the write data |
| toCount | input | TO_W | Timeout length in character times, 0 = off |
| flowEn | input | 1 | Hardware flow control enable |
| flowPol | input | 1 | Asserted level of request-to-send |
| charTick | input | 1 | One-cycle strobe per character time |
| txPush | input | 1 | Push into transmit queue |
| txData | input | DW | Character to push into transmit queue |
| txPop | input | 1 | Transmitter takes the oldest character |
| txRdData | output | DW | Oldest transmit character |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxPush | input | 1 | Receiver pushes a character |
| rxData | input | DW | Received character |
| rxPop | input | 1 | Software reads the oldest character |
| rxRdData | output | DW | Oldest received character |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| txFlushBusy | output | 1 | Transmit flush in progress (bit read-back) |
| rxFlushBusy | output | 1 | Receive flush in progress (bit read-back) |
| clkEnOut | output | 1 | Enable for the UART clock gate |
| rtsOut | output | 1 | Request-to-send pin level |
| toIrq | output | 1 | Receive idle timeout interrupt |

## Verification
The timeout is tried with a table of programmed counts against tick totals one short of the count, equal to it and far past it. This separates an off-by-one in the counter from a correct compare, and a count of zero shows whether the disable is honoured. A read in the middle of a count, followed by a tick sweep, tells a counter that restarts from one that only pauses. The request-to-send check sweeps the fill level across 14, 15, 13 and 12 entries, so each hysteresis threshold is probed on both sides, and then flips polarity and flow enable. Flush writes with the bit at 1 and at 0, and a push placed inside the busy window, show the self-clearing read-back and the dropped pushes.

// File: rtl/uqPkg.sv
package uqPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrTx;    // reset transmit queue pointers this cycle
    logic clrRx;    // reset receive queue pointers this cycle
    logic blockTx;  // refuse transmit push/pop
    logic blockRx;  // refuse receive push/pop
  } uqStrobe_t;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;

  // Flow-control hysteresis thresholds in free entries
  localparam int RTS_STOP_FREE = 2;
  localparam int RTS_GO_FREE   = 4;
endpackage

// File: rtl/uqFifo.sv
module uqFifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] popData,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          isFull, isEmpty, pushOk, popOk;

  assign isFull  = (level == LW'(DEPTH));
  assign isEmpty = (level == '0);
  assign pushOk  = push & ~isFull & ~clear;
  assign popOk   = pop & ~isEmpty & ~clear;
  assign popData = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/uqDatapath.sv
module uqDatapath import uqPkg::*; #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  uqStrobe_t     strobe,
  input  logic          txPush,
  input  logic [DW-1:0] txData,
  input  logic          txPop,
  output logic [DW-1:0] txRdData,
  output logic          txFull,
  output logic          txEmpty,
  input  logic          rxPush,
  input  logic [DW-1:0] rxData,
  input  logic          rxPop,
  output logic [DW-1:0] rxRdData,
  output logic          rxFull,
  output logic          rxEmpty,
  output logic [LW-1:0] rxLevel,
  output logic          rxPopFire
);
  logic [1:0]           chPush, chPop, chClr, chBlock;
  logic [1:0][DW-1:0]   chWr, chRd;
  logic [1:0][LW-1:0]   chLvl;
  logic [1:0]           chFull, chEmpty;

  assign chClr[CH_TX]   = strobe.clrTx;
  assign chClr[CH_RX]   = strobe.clrRx;
  assign chBlock[CH_TX] = strobe.blockTx;
  assign chBlock[CH_RX] = strobe.blockRx;
  assign chWr[CH_TX]    = txData;
  assign chWr[CH_RX]    = rxData;
  assign chPush[CH_TX]  = txPush & ~chBlock[CH_TX];
  assign chPush[CH_RX]  = rxPush & ~chBlock[CH_RX];
  assign chPop[CH_TX]   = txPop  & ~chBlock[CH_TX];
  assign chPop[CH_RX]   = rxPop  & ~chBlock[CH_RX];

  for (genvar ch = 0; ch < 2; ch++) begin : gQueue
    uqFifo #(.DW(DW), .DEPTH(DEPTH)) uQueue (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (chClr[ch]),
      .push    (chPush[ch]),
      .pushData(chWr[ch]),
      .pop     (chPop[ch]),
      .popData (chRd[ch]),
      .level   (chLvl[ch])
    );
    assign chFull[ch]  = (chLvl[ch] == LW'(DEPTH));
    assign chEmpty[ch] = (chLvl[ch] == '0);
  end

  assign txRdData  = chRd[CH_TX];
  assign txFull    = chFull[CH_TX];
  assign txEmpty   = chEmpty[CH_TX];
  assign rxRdData  = chRd[CH_RX];
  assign rxFull    = chFull[CH_RX];
  assign rxEmpty   = chEmpty[CH_RX];
  assign rxLevel   = chLvl[CH_RX];
  assign rxPopFire = chPop[CH_RX] & ~chEmpty[CH_RX] & ~chClr[CH_RX];
endmodule

// File: rtl/uqCtrl.sv
module uqCtrl import uqPkg::*; #(
  parameter int DEPTH = 16,
  parameter int TO_W  = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            ctlWrite,
  input  logic            ctlTxFlush,
  input  logic            ctlRxFlush,
  input  logic [TO_W-1:0] toCount,
  input  logic            flowEn,
  input  logic            flowPol,
  input  logic            charTick,
  input  logic [LW-1:0]   rxLevel,
  input  logic            rxPopFire,
  output uqStrobe_t       strobe,
  output logic            txFlushBusy,
  output logic            rxFlushBusy,
  output logic            rtsOut,
  output logic            toIrq
);
  logic [1:0] flushReq, busy, clrPulse;

  assign flushReq = {ctlRxFlush, ctlTxFlush} & {2{ctlWrite}};

  // Per-queue flush sequencer: set -> clear pointers -> drop busy
  for (genvar ch = 0; ch < 2; ch++) begin : gFlush
    logic busyQ, phaseQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyQ  <= 1'b0;
        phaseQ <= 1'b0;
      end else if (busyQ && !phaseQ) begin
        phaseQ <= 1'b1;
      end else if (busyQ) begin
        busyQ  <= 1'b0;
        phaseQ <= 1'b0;
      end else if (flushReq[ch]) begin
        busyQ  <= 1'b1;
      end
    end
    assign busy[ch]     = busyQ;
    assign clrPulse[ch] = busyQ & ~phaseQ;
  end

  assign strobe.clrTx   = clrPulse[CH_TX] | ~enable;
  assign strobe.clrRx   = clrPulse[CH_RX] | ~enable;
  assign strobe.blockTx = busy[CH_TX] | ~enable;
  assign strobe.blockRx = busy[CH_RX] | ~enable;
  assign txFlushBusy    = busy[CH_TX];
  assign rxFlushBusy    = busy[CH_RX];

  // Receive idle timeout in character times
  logic [TO_W-1:0] toCnt;
  logic            irqQ, restart;

  assign restart = ~enable | strobe.clrRx | rxPopFire | (rxLevel == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt <= '0;
      irqQ  <= 1'b0;
    end else if (restart) begin
      toCnt <= '0;
      irqQ  <= 1'b0;
    end else if (charTick && (toCount != '0) && !irqQ) begin
      toCnt <= toCnt + 1'b1;
      if (({1'b0, toCnt} + (TO_W+1)'(1)) >= {1'b0, toCount}) irqQ <= 1'b1;
    end
  end
  assign toIrq = irqQ;

  // Request-to-send hysteresis on free entries
  logic [LW-1:0] freeSlots;
  logic          rtsOn;

  assign freeSlots = LW'(DEPTH) - rxLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                rtsOn <= 1'b1;
    else if (freeSlots < LW'(RTS_STOP_FREE))  rtsOn <= 1'b0;
    else if (freeSlots >= LW'(RTS_GO_FREE))   rtsOn <= 1'b1;
  end

  assign rtsOut = (!flowEn || rtsOn) ? flowPol : ~flowPol;
endmodule

// File: rtl/uartQueueCtl.sv
module uartQueueCtl import uqPkg::*; #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int TO_W  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            ctlWrite,
  input  logic            ctlTxFlush,
  input  logic            ctlRxFlush,
  input  logic [TO_W-1:0] toCount,
  input  logic            flowEn,
  input  logic            flowPol,
  input  logic            charTick,
  input  logic            txPush,
  input  logic [DW-1:0]   txData,
  input  logic            txPop,
  output logic [DW-1:0]   txRdData,
  output logic            txFull,
  output logic            txEmpty,
  input  logic            rxPush,
  input  logic [DW-1:0]   rxData,
  input  logic            rxPop,
  output logic [DW-1:0]   rxRdData,
  output logic            rxFull,
  output logic            rxEmpty,
  output logic            txFlushBusy,
  output logic            rxFlushBusy,
  output logic            clkEnOut,
  output logic            rtsOut,
  output logic            toIrq
);
  localparam int LW = $clog2(DEPTH) + 1;

  uqStrobe_t     strobe;
  logic [LW-1:0] rxLevel;
  logic          rxPopFire;

  assign clkEnOut = enable;

  uqCtrl #(.DEPTH(DEPTH), .TO_W(TO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .ctlWrite(ctlWrite), .ctlTxFlush(ctlTxFlush), .ctlRxFlush(ctlRxFlush),
    .toCount(toCount), .flowEn(flowEn), .flowPol(flowPol), .charTick(charTick),
    .rxLevel(rxLevel), .rxPopFire(rxPopFire), .strobe(strobe),
    .txFlushBusy(txFlushBusy), .rxFlushBusy(rxFlushBusy),
    .rtsOut(rtsOut), .toIrq(toIrq)
  );

  uqDatapath #(.DW(DW), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txPush(txPush), .txData(txData), .txPop(txPop),
    .txRdData(txRdData), .txFull(txFull), .txEmpty(txEmpty),
    .rxPush(rxPush), .rxData(rxData), .rxPop(rxPop),
    .rxRdData(rxRdData), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxLevel(rxLevel), .rxPopFire(rxPopFire)
  );
endmodule

// File: rtl/uqChecker.sv
module uqChecker #(
  parameter int DEPTH = 16,
  parameter int TO_W  = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            txFlushBusy,
  input logic            rxFlushBusy,
  input logic            txEmpty,
  input logic            rxEmpty,
  input logic            flowEn,
  input logic            flowPol,
  input logic            rtsOut,
  input logic            toIrq,
  input logic [TO_W-1:0] toCount,
  input logic [LW-1:0]   rxLevel
);
  AST_TX_BUSY_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (txFlushBusy && $past(txFlushBusy)) |=> !txFlushBusy); // R2
  AST_TX_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFlushBusy) |-> txEmpty); // R2
  AST_RX_BUSY_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlushBusy && $past(rxFlushBusy)) |=> !rxFlushBusy); // R3
  AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txEmpty && rxEmpty && !toIrq)); // R5
  AST_IRQ_NEEDS_ZERO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toIrq) |-> ($past(toCount) != '0)); // R8
  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    toIrq |-> !rxEmpty); // R9
  AST_RTS_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (flowEn && ($past(rxLevel) > LW'(DEPTH - 2))) |-> (rtsOut == ~flowPol)); // R10
endmodule

bind uartQueueCtl uqChecker #(.DEPTH(DEPTH), .TO_W(TO_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable),
  .txFlushBusy(txFlushBusy), .rxFlushBusy(rxFlushBusy),
  .txEmpty(txEmpty), .rxEmpty(rxEmpty),
  .flowEn(flowEn), .flowPol(flowPol), .rtsOut(rtsOut), .toIrq(toIrq),
  .toCount(toCount), .rxLevel(rxLevel)
);

// File: tb/uartQueueCtl_test.sv
`timescale 1ns/1ps
module uartQueueCtl_test;
  localparam int DW = 8, DEPTH = 16, TO_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic enable, ctlWrite, ctlTxFlush, ctlRxFlush, flowEn, flowPol, charTick;
  logic [TO_W-1:0] toCount;
  logic txPush, txPop, rxPush, rxPop;
  logic [DW-1:0] txData, rxData, txRdData, rxRdData;
  logic txFull, txEmpty, rxFull, rxEmpty, txFlushBusy, rxFlushBusy;
  logic clkEnOut, rtsOut, toIrq;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  uartQueueCtl #(.DW(DW), .DEPTH(DEPTH), .TO_W(TO_W)) uut (.*);

  // {toCount, ticks, expected irq}
  localparam logic [16:0] TO_VEC [8] = '{
    {8'd3,  8'd2,  1'b0}, {8'd3,  8'd3,  1'b1}, {8'd1,  8'd1,  1'b1},
    {8'd0,  8'd20, 1'b0}, {8'd5,  8'd4,  1'b0}, {8'd5,  8'd9,  1'b1},
    {8'd40, 8'd39, 1'b0}, {8'd40, 8'd40, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushTx(input logic [DW-1:0] d);
    txPush = 1'b1; txData = d; @(negedge clk); txPush = 1'b0;
  endtask

  task automatic pushRx(input logic [DW-1:0] d);
    rxPush = 1'b1; rxData = d; @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic popRx();
    rxPop = 1'b1; @(negedge clk); rxPop = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin charTick = 1'b1; @(negedge clk); end
    charTick = 1'b0;
  endtask

  task automatic flushRx();
    ctlWrite = 1'b1; ctlRxFlush = 1'b1; @(negedge clk);
    ctlWrite = 1'b0; ctlRxFlush = 1'b0; idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    enable = 1; ctlWrite = 0; ctlTxFlush = 0; ctlRxFlush = 0;
    flowEn = 0; flowPol = 0; charTick = 0; toCount = '0;
    txPush = 0; txPop = 0; rxPush = 0; rxPop = 0; txData = '0; rxData = '0;
    idle(3); rstN = 1'b1; idle(1);

    // reset state
    chk("reset txEmpty", txEmpty, 1);
    chk("reset rxEmpty", rxEmpty, 1);
    chk("reset R2 busy", txFlushBusy, 0);
    chk("reset R3 busy", rxFlushBusy, 0);
    chk("reset R6 irq", toIrq, 0);
    chk("reset R11 rts", rtsOut, 0);
    chk("reset R5 clkEn", clkEnOut, 1);

    // R1: order, full, dropped push
    for (int i = 0; i < DEPTH; i++) pushTx(8'h10 + 8'(i));
    chk("R1 full", txFull, 1);
    pushTx(8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R1 order", txRdData, 8'h10 + 8'(i));
      txPop = 1'b1; @(negedge clk); txPop = 1'b0;
    end
    chk("R1 empty after drain", txEmpty, 1);

    // R4: write with flush bits at 0
    pushTx(8'hA1); pushTx(8'hA2);
    ctlWrite = 1'b1; @(negedge clk); ctlWrite = 1'b0; idle(2);
    chk("R4 not emptied", txEmpty, 0);
    chk("R4 no busy", txFlushBusy, 0);
    chk("R4 data kept", txRdData, 8'hA1);

    // R2: transmit flush
    ctlWrite = 1'b1; ctlTxFlush = 1'b1; @(negedge clk);
    ctlWrite = 1'b0; ctlTxFlush = 1'b0;
    chk("R2 busy cycle1", txFlushBusy, 1);
    txPush = 1'b1; txData = 8'h77; @(negedge clk); txPush = 1'b0;
    chk("R2 busy cycle2", txFlushBusy, 1);
    chk("R2 emptied", txEmpty, 1);
    idle(1);
    chk("R2 self clear", txFlushBusy, 0);
    chk("R2 push in window dropped", txEmpty, 1);

    // R3 with R6: receive flush clears pending irq
    pushRx(8'h31); toCount = 8'd2; ticks(2);
    chk("R6 irq at count", toIrq, 1);
    ctlWrite = 1'b1; ctlRxFlush = 1'b1; @(negedge clk);
    ctlWrite = 1'b0; ctlRxFlush = 1'b0;
    chk("R3 busy cycle1", rxFlushBusy, 1);
    idle(1);
    chk("R3 emptied", rxEmpty, 1);
    chk("R3 irq cleared", toIrq, 0);
    idle(1);
    chk("R3 self clear", rxFlushBusy, 0);

    // R6/R8 table
    for (int v = 0; v < 8; v++) begin
      flushRx();
      pushRx(8'h5A);
      toCount = TO_VEC[v][16:9];
      ticks(int'(TO_VEC[v][8:1]));
      chk($sformatf("R6/R8 vector %0d", v), toIrq, TO_VEC[v][0]);
    end

    // R7: read restarts count
    flushRx();
    pushRx(8'h01); pushRx(8'h02);
    toCount = 8'd4; ticks(3);
    popRx();
    ticks(3);
    chk("R7 restart after read", toIrq, 0);
    ticks(1);
    chk("R7 fires after full count", toIrq, 1);

    // R9: sticky until read
    ticks(5);
    chk("R9 still pending", toIrq, 1);
    popRx();
    chk("R9 cleared by read", toIrq, 0);

    // R5: disable
    pushTx(8'h44); pushRx(8'h55);
    enable = 1'b0; @(negedge clk);
    chk("R5 tx emptied", txEmpty, 1);
    chk("R5 rx emptied", rxEmpty, 1);
    chk("R5 clkEn low", clkEnOut, 0);
    pushRx(8'h66);
    chk("R5 push dropped", rxEmpty, 1);
    enable = 1'b1; idle(1);
    chk("R5 stays empty", rxEmpty, 1);

    // R10/R11: flow control hysteresis, active low
    toCount = '0; flowEn = 1'b1; flowPol = 1'b0;
    for (int i = 0; i < DEPTH - 2; i++) pushRx(8'(i));
    idle(1);
    chk("R10 asserted at 2 free", rtsOut, 0);
    pushRx(8'hF0); idle(1);
    chk("R10 deasserted at 1 free", rtsOut, 1);
    popRx(); popRx(); idle(1);
    chk("R10 held at 3 free", rtsOut, 1);
    popRx(); idle(1);
    chk("R10 reasserted at 4 free", rtsOut, 0);
    flowPol = 1'b1; idle(1);
    chk("R11 active high", rtsOut, 1);
    flowEn = 1'b0; flowPol = 1'b0; idle(1);
    chk("R11 flow off low", rtsOut, 0);
    flowPol = 1'b1; idle(1);
    chk("R11 flow off high", rtsOut, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule